// File: doc/BRIEF.md
# Block-Averaging Oversampling Decimator

This block reduces the noise of a converter sample stream by averaging. Samples arrive with a one-cycle valid strobe on one or two channels that are sampled at the same instant. The block adds up M consecutive samples of each channel into a group and divides the group sum by M. It then emits one averaged result per channel and starts a new group. The output rate is therefore the input rate divided by M. M is a runtime power of two from 2 to 32, and the ratio code zero turns averaging off so that samples pass straight through.

A boost input keeps two bits of the quotient's fraction. The result then carries two extra LSBs, and its value is four times the average. The division is a shift by log2(M), so there is no divider. When the ratio or the boost setting changes, any partly built group is thrown away, so the next result uses only samples taken under the new setting. Both channels share one group counter. Their results are always published in the same cycle under one valid strobe.

Top module: `ovs_block_avg`

## Requirements
- R1: While reset is low, and after it is released, `out_valid` is 0 and `out_data` is all zeros until the first result is produced.
- R2: With ratio code k in 1..5, M = 2^k. Codes 6 and 7 behave as M = 32. With boost off, each result is floor(sum/M) of its group, where sum is the sum of the group's M samples (floor toward minus infinity for signed samples).
- R3: Groups do not overlap. Exactly one result comes out per M accepted samples. `out_valid` is high for exactly the one clock cycle that follows the edge capturing the M-th sample of a group, and is low in every other cycle.
- R4: With ratio code 0, every accepted sample appears on the output in the cycle after it is accepted, with `out_valid` high.
- R5: With boost on, each result is floor(4*sum/M). In pass-through mode this is the sample multiplied by 4, with the two low bits zero.
- R6: Each channel's result is OUT_W = SAMPLE_W+2 bits wide. With boost off, the average is sign-extended (signed build) or zero-extended (unsigned build) to that width.
- R7: The accumulator is SAMPLE_W+5 bits wide and gives exact results for 32 full-scale samples of either polarity.
- R8: A change of the ratio code or of the boost input discards the partial group. The next result uses only samples accepted from the change on.
- R9: Channel c uses bits [c*W +: W] of both `in_data` and `out_data`. All channels share a single `out_valid`.
- R10: A cycle with `in_valid` low does not advance the group and produces no result in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osr_code | input | 3 | Ratio code: 0 = pass-through, k = average 2^k samples |
| boost_en | input | 1 | Keep two fractional bits of the average |
| in_valid | input | 1 | Sample strobe for all channels |
| in_data | input | NUM_CH*SAMPLE_W | Packed channel samples |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | NUM_CH*(SAMPLE_W+2) | Packed channel results |

## Verification
The bench builds two instances with 6-bit samples and two channels. One instance is signed and one is unsigned, and both are fed the same raw bit patterns. At 6 bits, full scale, both polarities of the floor rounding and the 32-sample accumulator limit can all be reached with a few hundred samples. This lets the bench sweep all eight ratio codes, with boost both on and off, across several groups with idle gaps between samples. Short partial groups followed by setting changes exercise the discard of a half-built group.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
   localparam int unsigned CODE_W = 3;

   function automatic logic [CODE_W-1:0] clamp_log(input logic [CODE_W-1:0] code,
                                                   input int unsigned lim);
      logic [CODE_W-1:0] l;
      l = CODE_W'(lim);
      return (code > l) ? l : code;
   endfunction
endpackage

// File: rtl/ovs_group_ctrl.sv
module ovs_group_ctrl
   import ovs_pkg::*;
#(
   parameter int unsigned MAX_LOG2 = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] osr_code,
   input  logic              boost_en,
   input  logic              in_valid,
   output logic [CODE_W-1:0] ratio_log,
   output logic              cfg_change,
   output logic              last_smp,
   output logic              out_valid
);
   localparam int unsigned CNT_W = MAX_LOG2;

   logic [CODE_W-1:0] code_q;
   logic              boost_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_base;
   logic [CNT_W-1:0]  mask;
   logic              vld_q;

   assign ratio_log  = clamp_log(osr_code, MAX_LOG2);
   assign cfg_change = (osr_code != code_q) || (boost_en != boost_q);
   assign mask       = CNT_W'((32'd1 << ratio_log) - 32'd1);
   assign cnt_base   = cfg_change ? '0 : cnt_q;
   assign last_smp   = (ratio_log == '0) || (cnt_base == mask);
   assign out_valid  = vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         boost_q <= 1'b0;
         cnt_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         code_q  <= osr_code;
         boost_q <= boost_en;
         vld_q   <= in_valid && last_smp;
         if (in_valid)
            cnt_q <= last_smp ? '0 : cnt_base + CNT_W'(1);
         else
            cnt_q <= cnt_base;
      end
   end

   AST_CNT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_change |-> (cnt_q <= mask)); // R3

   AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_change && !in_valid) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/ovs_chan_acc.sv
module ovs_chan_acc
   import ovs_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned MAX_LOG2  = 5,
   parameter bit          SIGNED_IN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [SAMPLE_W-1:0]   sample,
   input  logic                  clr,
   input  logic                  last_smp,
   input  logic [CODE_W-1:0]     ratio_log,
   input  logic                  boost_en,
   output logic [SAMPLE_W+1:0]   result
);
   localparam int unsigned ACC_W = SAMPLE_W + MAX_LOG2;
   localparam int unsigned OUT_W = SAMPLE_W + 2;
   localparam int unsigned WID_W = ACC_W + 2;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] base;
   logic [ACC_W-1:0] smp_ext;
   logic [ACC_W:0]   sum_x;
   logic [ACC_W-1:0] sum;
   logic [WID_W-1:0] wide;
   logic [WID_W-1:0] shifted;
   logic [OUT_W-1:0] res_q;
   logic             ovf;

   assign base = clr ? '0 : acc_q;
   assign sum  = sum_x[ACC_W-1:0];

   generate
      if (SIGNED_IN) begin : g_signed
         assign smp_ext = {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
         assign sum_x   = {base[ACC_W-1], base} + {smp_ext[ACC_W-1], smp_ext};
         assign ovf     = sum_x[ACC_W] != sum_x[ACC_W-1];
         assign wide    = boost_en ? {sum, 2'b00} : {{2{sum[ACC_W-1]}}, sum};
         assign shifted = WID_W'($signed(wide) >>> ratio_log);
      end else begin : g_unsigned
         assign smp_ext = {{(ACC_W-SAMPLE_W){1'b0}}, sample};
         assign sum_x   = {1'b0, base} + {1'b0, smp_ext};
         assign ovf     = sum_x[ACC_W];
         assign wide    = boost_en ? {sum, 2'b00} : {2'b00, sum};
         assign shifted = wide >> ratio_log;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         res_q <= '0;
      end else if (in_valid) begin
         if (last_smp) begin
            res_q <= shifted[OUT_W-1:0];
            acc_q <= '0;
         end else begin
            acc_q <= sum;
         end
      end else if (clr) begin
         acc_q <= '0;
      end
   end

   assign result = res_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !ovf); // R7

   AST_GROUP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && last_smp) |=> (acc_q == '0)); // R3
endmodule

// File: rtl/ovs_block_avg.sv
module ovs_block_avg
   import ovs_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned NUM_CH    = 2,
   parameter bit          SIGNED_IN = 1'b1,
   parameter int unsigned MAX_LOG2  = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [2:0]                       osr_code,
   input  logic                             boost_en,
   input  logic                             in_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0]       in_data,
   output logic                             out_valid,
   output logic [NUM_CH*(SAMPLE_W+2)-1:0]   out_data
);
   localparam int unsigned OUT_W = SAMPLE_W + 2;

   generate
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
         $error("ovs_block_avg: NUM_CH must be 1 or 2");
      end
      if (MAX_LOG2 < 1 || MAX_LOG2 > 5) begin : g_bad_ratio
         $error("ovs_block_avg: MAX_LOG2 must be within 1..5");
      end
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("ovs_block_avg: SAMPLE_W must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] ratio_log;
   logic              cfg_change;
   logic              last_smp;

   ovs_group_ctrl #(.MAX_LOG2(MAX_LOG2)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .osr_code   (osr_code),
      .boost_en   (boost_en),
      .in_valid   (in_valid),
      .ratio_log  (ratio_log),
      .cfg_change (cfg_change),
      .last_smp   (last_smp),
      .out_valid  (out_valid)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ovs_chan_acc #(
         .SAMPLE_W  (SAMPLE_W),
         .MAX_LOG2  (MAX_LOG2),
         .SIGNED_IN (SIGNED_IN)
      ) u_acc (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_valid),
         .sample    (in_data[c*SAMPLE_W +: SAMPLE_W]),
         .clr       (cfg_change),
         .last_smp  (last_smp),
         .ratio_log (ratio_log),
         .boost_en  (boost_en),
         .result    (out_data[c*OUT_W +: OUT_W])
      );
   end

   AST_PASS_EACH: assert property (@(posedge clk) disable iff (!rst_n)
      (osr_code == 3'd0 && in_valid) |=> out_valid); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R10

   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R3
endmodule

// File: tb/ovs_block_avg_tb_top.sv
module ovs_block_avg_tb_top;
   localparam int SW = 6;
   localparam int OW = SW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    osr = 3'd0;
   logic          boost = 1'b0;
   logic          vld = 1'b0;
   logic [2*SW-1:0] din = '0;
   logic          ov_s, ov_u;
   logic [2*OW-1:0] od_s, od_u;

   integer checks = 0;
   integer errors = 0;
   integer m_n = 0, m_M = 1, m_code = 0, m_boost = 0;
   integer s0 = 0, s1 = 0, u0 = 0, u1 = 0;
   string  tag = "";

   always #10 clk = ~clk;

   ovs_block_avg #(.SAMPLE_W(SW), .NUM_CH(2), .SIGNED_IN(1'b1), .MAX_LOG2(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .osr_code(osr), .boost_en(boost),
      .in_valid(vld), .in_data(din), .out_valid(ov_s), .out_data(od_s));

   ovs_block_avg #(.SAMPLE_W(SW), .NUM_CH(2), .SIGNED_IN(1'b0), .MAX_LOG2(5)) dut_u (
      .clk(clk), .rst_n(rst_n), .osr_code(osr), .boost_en(boost),
      .in_valid(vld), .in_data(din), .out_valid(ov_u), .out_data(od_u));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic integer fdiv(input integer a, input integer b);
      if (a < 0 && (a % b) != 0) return a / b - 1;
      return a / b;
   endfunction

   function automatic integer sval(input logic [SW-1:0] r);
      return (r >= 32) ? integer'(r) - 64 : integer'(r);
   endfunction

   task automatic clear_model();
      m_n = 0; s0 = 0; s1 = 0; u0 = 0; u1 = 0;
   endtask

   task automatic set_cfg(input integer code, input integer b);
      osr = 3'(code);
      boost = b[0];
      vld = 1'b0;
      @(negedge clk);
      chk("R10 idle", {31'd0, ov_s}, 32'd0);
      m_code = code;
      m_boost = b;
      m_M = (code == 0) ? 1 : ((code > 5) ? 32 : (1 << code));
      clear_model();
   endtask

   task automatic idle();
      vld = 1'b0;
      @(negedge clk);
      chk("R10", {31'd0, ov_s}, 32'd0);
      chk("R10", {31'd0, ov_u}, 32'd0);
   endtask

   task automatic push(input logic [SW-1:0] a0, input logic [SW-1:0] a1);
      string r;
      integer k;
      vld = 1'b1;
      din = {a1, a0};
      @(negedge clk);
      s0 += sval(a0); s1 += sval(a1);
      u0 += integer'(a0); u1 += integer'(a1);
      m_n++;
      if (m_n == m_M) begin
         k = m_boost ? 4 : 1;
         r = (tag != "") ? tag : ((m_code == 0) ? "R4" : (m_boost ? "R5" : "R2"));
         chk("R3 valid", {31'd0, ov_s}, 32'd1);
         chk("R9 valid", {31'd0, ov_u}, 32'd1);
         chk(r, {24'd0, od_s[OW-1:0]}, {24'd0, 8'(fdiv(k * s0, m_M))});
         chk({r, " R9"}, {24'd0, od_s[2*OW-1:OW]}, {24'd0, 8'(fdiv(k * s1, m_M))});
         chk({r, " R6"}, {24'd0, od_u[OW-1:0]}, {24'd0, 8'((k * u0) / m_M)});
         chk({r, " R9"}, {24'd0, od_u[2*OW-1:OW]}, {24'd0, 8'((k * u1) / m_M)});
         clear_model();
      end else begin
         chk("R3 no early result", {31'd0, ov_s}, 32'd0);
      end
      vld = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 valid", {31'd0, ov_s}, 32'd0);
      chk("R1 data", {16'd0, od_s}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {16'd0, od_u}, 32'd0);

      // ratio sweep, both boost settings, with idle gaps
      for (int code = 0; code < 8; code++) begin
         for (int b = 0; b < 2; b++) begin
            set_cfg(code, b);
            for (int g = 0; g < 3; g++) begin
               for (int j = 0; j < m_M; j++) begin
                  push(SW'((j * 29 + g * 13 + code * 7 + b * 5 + (j * j) % 7) % 64),
                       SW'((j * 17 + g * 31 + code * 3 + 40) % 64));
                  if ((j % 5) == 3) idle();
               end
            end
         end
      end

      // R8: partial group discarded on ratio change
      tag = "R8";
      set_cfg(2, 0);
      push(6'd20, 6'd3);
      push(6'd21, 6'd50);
      set_cfg(1, 0);
      push(6'd2, 6'd60);
      push(6'd5, 6'd33);
      // R8: partial group discarded on boost change
      set_cfg(3, 0);
      for (int j = 0; j < 3; j++) push(6'd31, 6'd32);
      set_cfg(3, 1);
      for (int j = 0; j < 8; j++) push(SW'(j * 9), SW'(63 - j));

      // R7: full-scale groups of 32
      tag = "R7";
      set_cfg(5, 1);
      for (int j = 0; j < 32; j++) push(6'd32, 6'd63);
      set_cfg(5, 0);
      for (int j = 0; j < 32; j++) push(6'd31, 6'd63);
      for (int j = 0; j < 32; j++) push(6'd32, 6'd0);
      tag = "";

      idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule